// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This unit steers a non-pipelined processor core into an interrupt handler and back out again. It takes one hardware interrupt line and software interrupt requests that carry a 5-bit vector number. On entry it saves the current program counter on a dedicated return-address stack and then fetches the handler address from a 32-slot pointer table in memory. That table starts at a base address supplied by the core. The unit then hands the core a new program counter and a new return-stack pointer. A return-from-interrupt request pops the saved program counter back off the same stack. The data stack is never touched.

The core presents an instruction-boundary strobe. Requests are only sampled while that strobe is high and the unit is idle. A hardware request is always served through slot 8 and is gated by an interrupt-enable flag. That flag starts set, is cleared by every entry and is set again by a return. A hardware pulse that cannot be served yet is remembered until it can be. Memory traffic uses a simple request/acknowledge port with any latency. The unit stays busy from acceptance until the cycle in which it loads the program counter.

Top module: `irq_dispatch`

## Requirements
- R1: A software request with vector v loads the program counter with the 32-bit word read at address itb + 4*v. Vectors 0 and 31 behave like any other vector.
- R2: On entry, the first memory access is a write of cur_pc to address rsp - 4. When the program counter is loaded, rsp_load is high in the same cycle and rsp_next equals rsp - 4.
- R3: A hardware entry loads the program counter from the word at itb + 4*8, and it pushes cur_pc in the same way as R2.
- R4: After reset, ie is 1. Every entry clears ie. A hardware request is accepted only while ie is 1, and while ie is 0 a hardware request with the boundary strobe high starts no activity.
- R5: A return request reads the word at rsp and loads it into the program counter. rsp_next equals rsp + 4, and ie is 1 afterwards.
- R6: When software and hardware requests arrive in the same sampled cycle, the software vector is served first. The hardware request stays pending and is served, through slot 8, at the first sampled boundary after ie is set again.
- R7: busy is high from the cycle after acceptance until the cycle in which pc_load pulses for one cycle, and it is low in the cycle after that. mem_req is only ever high while busy is high.
- R8: Software and return requests have no effect unless boundary is high. A hardware pulse seen without boundary is held pending and is served at a later sampled boundary.
- R9: While mem_req is high and mem_ack is low, mem_addr, mem_we and mem_wdata hold their values. Each mem_ack completes exactly one access, and any acknowledge latency gives the same result.
- R10: Priority among requests sampled in the same cycle is software, then return, then hardware.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary | input | 1 | Core is at an instruction boundary |
| hw_req | input | 1 | Hardware interrupt request (pulse or level) |
| sw_req | input | 1 | Software interrupt request |
| sw_vec | input | 5 | Vector number of the software request |
| ret_req | input | 1 | Return-from-interrupt request |
| cur_pc | input | 32 | Program counter to save on entry |
| itb | input | 32 | Base address of the handler table |
| rsp | input | 32 | Current return-stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| pc_load | output | 1 | Load pc_next into the program counter |
| pc_next | output | 32 | New program counter |
| rsp_load | output | 1 | Load rsp_next into the return-stack pointer |
| rsp_next | output | 32 | New return-stack pointer |
| ie | output | 1 | Interrupt-enable flag |
| busy | output | 1 | A dispatch or return sequence is in progress |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, 5-bit vectors, 4-byte table slots and slot 8 for the hardware line. With these values both ends of the table (slots 0 and 31) and the hardware slot all sit inside a small modelled memory, next to a downward-growing stack. The memory model's acknowledge latency is switched between zero and several cycles, so that handshake stalls occur in the middle of both pushes and table reads. Collisions between software, return and hardware requests are set up on a single sampled boundary to exercise the ordering rules.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int AW         = 32;
  localparam int VW         = 5;
  localparam int SLOT_SHIFT = 2;

  typedef logic [AW-1:0] addr_t;
  typedef logic [VW-1:0] vec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_FETCH_VECTOR,
    ST_POP,
    ST_LOAD_PC
  } seq_state_t;

  // Address of the table slot that holds the handler pointer
  function automatic addr_t slot_addr(addr_t base, vec_t v);
    return base + (addr_t'(v) << SLOT_SHIFT);
  endfunction

  // Return stack grows toward lower addresses
  function automatic addr_t stack_down(addr_t sp);
    return sp - (addr_t'(1) << SLOT_SHIFT);
  endfunction

  function automatic addr_t stack_up(addr_t sp);
    return sp + (addr_t'(1) << SLOT_SHIFT);
  endfunction
endpackage

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter vec_t HW_VEC = vec_t'(8)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic boundary,
  input  logic hw_req,
  input  logic sw_req,
  input  vec_t sw_vec,
  input  logic ret_req,
  input  logic ret_done,
  output logic sw_take,
  output logic hw_take,
  output logic ret_take,
  output logic take_enter,
  output vec_t enter_vec,
  output logic ie
);
  logic hw_pend_q;
  logic ie_q;
  logic hw_any;
  logic sample;

  assign hw_any     = hw_pend_q | hw_req;
  assign sample     = idle & boundary;
  assign sw_take    = sample & sw_req;
  assign ret_take   = sample & ret_req & ~sw_req;
  assign hw_take    = sample & ~sw_req & ~ret_req & hw_any & ie_q;
  assign take_enter = sw_take | hw_take;
  assign enter_vec  = sw_take ? sw_vec : HW_VEC;
  assign ie         = ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_pend_q <= 1'b0;
      ie_q      <= 1'b1;
    end else begin
      hw_pend_q <= hw_any & ~hw_take;
      if (take_enter)    ie_q <= 1'b0;
      else if (ret_done) ie_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_enter,
  input  logic  take_ret,
  input  vec_t  enter_vec,
  input  addr_t cur_pc,
  input  addr_t itb,
  input  addr_t rsp,
  output logic  mem_req,
  output logic  mem_we,
  output addr_t mem_addr,
  output addr_t mem_wdata,
  input  logic  mem_ack,
  input  addr_t mem_rdata,
  output logic  pc_load,
  output addr_t pc_next,
  output logic  rsp_load,
  output addr_t rsp_next,
  output logic  busy,
  output logic  idle,
  output logic  ret_done
);
  seq_state_t state_q;
  addr_t      sp_q;
  addr_t      tab_q;
  addr_t      save_pc_q;
  addr_t      hdl_q;
  logic       is_ret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sp_q      <= '0;
      tab_q     <= '0;
      save_pc_q <= '0;
      hdl_q     <= '0;
      is_ret_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_enter) begin
            sp_q      <= stack_down(rsp);
            tab_q     <= slot_addr(itb, enter_vec);
            save_pc_q <= cur_pc;
            is_ret_q  <= 1'b0;
            state_q   <= ST_PUSH;
          end else if (take_ret) begin
            sp_q     <= rsp;
            is_ret_q <= 1'b1;
            state_q  <= ST_POP;
          end
        end
        ST_PUSH: if (mem_ack) state_q <= ST_FETCH_VECTOR;
        ST_FETCH_VECTOR: begin
          if (mem_ack) begin
            hdl_q   <= mem_rdata;
            state_q <= ST_LOAD_PC;
          end
        end
        ST_POP: begin
          if (mem_ack) begin
            hdl_q   <= mem_rdata;
            sp_q    <= stack_up(sp_q);
            state_q <= ST_LOAD_PC;
          end
        end
        ST_LOAD_PC: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    unique case (state_q)
      ST_PUSH:         begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_q;  end
      ST_FETCH_VECTOR: begin mem_req = 1'b1;                mem_addr = tab_q; end
      ST_POP:          begin mem_req = 1'b1;                mem_addr = sp_q;  end
      default: ;
    endcase
  end

  assign mem_wdata = save_pc_q;
  assign idle      = (state_q == ST_IDLE);
  assign busy      = ~idle;
  assign pc_load   = (state_q == ST_LOAD_PC);
  assign rsp_load  = pc_load;
  assign pc_next   = hdl_q;
  assign rsp_next  = sp_q;
  assign ret_done  = pc_load & is_ret_q;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter vec_t HW_VEC = vec_t'(8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          hw_req,
  input  logic          sw_req,
  input  logic [VW-1:0] sw_vec,
  input  logic          ret_req,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] itb,
  input  logic [AW-1:0] rsp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          pc_load,
  output logic [AW-1:0] pc_next,
  output logic          rsp_load,
  output logic [AW-1:0] rsp_next,
  output logic          ie,
  output logic          busy
);
  // Named internal events, visible to the bound checker
  logic sw_take;
  logic hw_take;
  logic ret_take;
  logic take_enter;
  logic idle;
  logic ret_done;
  vec_t enter_vec;

  irq_arb #(.HW_VEC(HW_VEC)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (idle),
    .boundary   (boundary),
    .hw_req     (hw_req),
    .sw_req     (sw_req),
    .sw_vec     (sw_vec),
    .ret_req    (ret_req),
    .ret_done   (ret_done),
    .sw_take    (sw_take),
    .hw_take    (hw_take),
    .ret_take   (ret_take),
    .take_enter (take_enter),
    .enter_vec  (enter_vec),
    .ie         (ie)
  );

  irq_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_enter (take_enter),
    .take_ret   (ret_take),
    .enter_vec  (enter_vec),
    .cur_pc     (cur_pc),
    .itb        (itb),
    .rsp        (rsp),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .pc_load    (pc_load),
    .pc_next    (pc_next),
    .rsp_load   (rsp_load),
    .rsp_next   (rsp_next),
    .busy       (busy),
    .idle       (idle),
    .ret_done   (ret_done)
  );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          pc_load,
  input logic          rsp_load,
  input logic          ie,
  input logic          sw_take,
  input logic          hw_take,
  input logic          ret_take,
  input logic          take_enter
);
  AST_PC_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n) pc_load |-> rsp_load); // R2
  AST_ENTRY_WRITES_FIRST: assert property (@(posedge clk) disable iff (!rst_n) take_enter |=> mem_req && mem_we); // R2
  AST_HW_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n) hw_take |-> ie); // R4
  AST_IE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) take_enter |=> !ie); // R4
  AST_RET_READS: assert property (@(posedge clk) disable iff (!rst_n) ret_take |=> mem_req && !mem_we); // R5
  AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) pc_load |=> !busy); // R7
  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_SW_FIRST: assert property (@(posedge clk) disable iff (!rst_n) sw_take |-> !hw_take && !ret_take); // R10
endmodule

bind irq_dispatch irq_dispatch_chk u_chk (.*);

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
  import irq_pkg::*;

  localparam logic [31:0] ITB = 32'h0000_0080;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, boundary, hw_req, sw_req, ret_req, mem_ack;
  logic [4:0]  sw_vec;
  logic [31:0] cur_pc, itb, rsp, mem_rdata;
  logic        mem_req, mem_we, pc_load, rsp_load, ie, busy;
  logic [31:0] mem_addr, mem_wdata, pc_next, rsp_next;

  irq_dispatch u0 (.*);

  int checks = 0, failures = 0;
  logic [31:0] mem [0:127];
  int lat = 0, lat_cnt = 0, n_ops = 0;
  logic first_we;
  logic [31:0] last_waddr, last_wdata, last_raddr;
  logic [31:0] ld_pc, ld_rsp;

  function automatic logic [31:0] tab(int v);
    return 32'hC000_0000 + (((ITB + 32'(v) * 4) >> 2) * 16);
  endfunction

  // Memory model: acknowledges after lat idle cycles
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat_cnt >= lat) begin
        lat_cnt = 0;
        mem_ack = 1'b1;
        if (n_ops == 0) first_we = mem_we;
        n_ops++;
        if (mem_we) begin
          mem[mem_addr[8:2]] = mem_wdata;
          last_waddr = mem_addr; last_wdata = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[8:2]];
          last_raddr = mem_addr;
        end
      end else lat_cnt++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic s, logic [4:0] v, logic r, logic h, logic b);
    @(negedge clk);
    sw_req = s; sw_vec = v; ret_req = r; hw_req = h; boundary = b;
    @(negedge clk);
    sw_req = 0; ret_req = 0; hw_req = 0; boundary = 0;
  endtask

  // Waits for pc_load, records the result and checks busy drops (R7)
  task automatic wait_load(string req);
    bit seen = 0;
    for (int k = 0; k < 100 && !seen; k++) begin
      if (pc_load) begin
        seen = 1; ld_pc = pc_next; ld_rsp = rsp_next;
      end else @(negedge clk);
    end
    chk({req, " load seen"}, 32'(seen), 32'd1);
    @(negedge clk);
    chk("R7 busy low after load", 32'(busy), 32'd0);
    rsp = ld_rsp;
  endtask

  task automatic t_enter(string req, logic s, logic [4:0] v, logic h, int slot, logic [31:0] pc);
    logic [31:0] sp0 = rsp;
    bit saw_busy;
    cur_pc = pc; n_ops = 0;
    pulse(s, v, 1'b0, h, 1'b1);
    saw_busy = busy;
    chk("R7 busy during entry", 32'(saw_busy), 32'd1);
    wait_load(req);
    chk({req, " handler"}, ld_pc, tab(slot));
    chk("R2 first access is write", 32'(first_we), 32'd1);
    chk("R2 push address", last_waddr, sp0 - 4);
    chk("R2 push data", last_wdata, pc);
    chk("R2 rsp_next", ld_rsp, sp0 - 4);
    chk("R9 two accesses", 32'(n_ops), 32'd2);
    chk("R4 ie cleared", 32'(ie), 32'd0);
  endtask

  task automatic t_ret(string req, logic h, logic [31:0] exp_pc);
    logic [31:0] sp0 = rsp;
    n_ops = 0;
    pulse(1'b0, 5'd0, 1'b1, h, 1'b1);
    wait_load(req);
    chk("R5 return pc", ld_pc, exp_pc);
    chk("R5 pop address", last_raddr, sp0);
    chk("R5 rsp_next", ld_rsp, sp0 + 4);
    chk("R5 first access is read", 32'(first_we), 32'd0);
    chk("R5 ie restored", 32'(ie), 32'd1);
  endtask

  task automatic t_idle(string req, int cycles);
    int hits = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (busy || mem_req || pc_load) hits++;
    end
    chk(req, 32'(hits), 32'd0);
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'hC000_0000 + 32'(i) * 16;
    rst_n = 0; boundary = 0; hw_req = 0; sw_req = 0; ret_req = 0; sw_vec = 0;
    mem_ack = 0; mem_rdata = 0; cur_pc = 0; itb = ITB; rsp = 32'h200;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset ie", 32'(ie), 32'd1);
    chk("R7 reset busy", 32'(busy), 32'd0);
    chk("R9 reset mem_req", 32'(mem_req), 32'd0);

    // R1 software entry, vector 20
    t_enter("R1 sw vec20", 1'b1, 5'd20, 1'b0, 20, 32'h0000_4000);
    // R4 hardware ignored while ie=0, boundary held high
    @(negedge clk); hw_req = 1; boundary = 1;
    @(negedge clk); hw_req = 0;
    t_idle("R4 hw ignored while ie=0", 4);
    boundary = 0;
    t_ret("R5 return", 1'b0, 32'h0000_4000);
    // R3 / R6 pending hardware served through slot 8
    t_enter("R3 hw slot8", 1'b0, 5'd0, 1'b0, 8, 32'h0000_5000);
    t_ret("R5 return hw", 1'b0, 32'h0000_5000);

    lat = 3;
    // R6 software and hardware together, vector 31
    t_enter("R6 sw first vec31", 1'b1, 5'd31, 1'b1, 31, 32'h0000_6000);
    t_ret("R5 return slow", 1'b0, 32'h0000_6000);
    t_enter("R6 hw after ie set", 1'b0, 5'd0, 1'b0, 8, 32'h0000_6100);
    t_ret("R5 return", 1'b0, 32'h0000_6100);

    lat = 1;
    // R1 vector 0
    t_enter("R1 sw vec0", 1'b1, 5'd0, 1'b0, 0, 32'h0000_7000);
    t_ret("R5 return vec0", 1'b0, 32'h0000_7000);

    // R8 no boundary: sw and ret ignored
    @(negedge clk); sw_req = 1; sw_vec = 5'd17;
    t_idle("R8 sw ignored without boundary", 3);
    sw_req = 0; ret_req = 1;
    t_idle("R8 ret ignored without boundary", 3);
    ret_req = 0;

    // R10 software beats return
    cur_pc = 32'h0000_8000; n_ops = 0;
    pulse(1'b1, 5'd18, 1'b1, 1'b0, 1'b1);
    wait_load("R10 sw over ret");
    chk("R10 sw over ret handler", ld_pc, tab(18));
    chk("R10 sw over ret first write", 32'(first_we), 32'd1);
    t_ret("R5 return", 1'b0, 32'h0000_8000);

    // R8 hw pulse without boundary stays pending; R10 ret beats hw
    pulse(1'b0, 5'd0, 1'b0, 1'b1, 1'b0);
    t_idle("R8 hw waits for boundary", 2);
    t_ret("R10 ret over hw", 1'b1, mem[rsp[8:2]]);
    t_enter("R8 pending hw served", 1'b0, 5'd0, 1'b0, 8, 32'h0000_9000);
    t_ret("R5 final return", 1'b0, 32'h0000_9000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule